// File: doc/BRIEF.md
# Reactive Power Event Interrupt Status

This block turns two conditions of a reactive energy measurement path into sticky status flags and a single interrupt request to a microcontroller. One flag records a change of the sign of the reactive power. The other records that the reactive power has dropped below the no-load level. The power computation feeds the block with a sample strobe, the sign of each sample, and a no-load indication. Software sets a per-flag enable mask and clears flags by writing ones to their bit positions.

A configuration bit chooses which sign change counts as an event. When the bit is low, a swing from positive to negative sets the flag. When it is high, a swing from negative to positive sets it. The block compares signs only between consecutive sample strobes, so the sign input may change freely between strobes. A flag that is set stays set until software clears it. The interrupt line is registered and stays asserted while any enabled flag remains set.

Top module: `pwr_evt_irq`

## Requirements
- R1: After reset, status reads 0, irq is low, and the remembered previous sign is positive.
- R2: With signPolarity low, a sample strobe with signNeg=1 sets status bit 0 when the previous strobe saw signNeg=0. The reset state counts as a positive previous sample.
- R3: With signPolarity high, a sample strobe with signNeg=0 sets status bit 0 when the previous strobe saw signNeg=1.
- R4: signNeg is ignored on cycles without sampleStb. It neither sets bit 0 nor changes the remembered sign.
- R5: A sample strobe with noLoad=1 sets status bit 1. noLoad is ignored without a strobe.
- R6: Status bits are sticky. A cycle with clrWe=1 clears each bit whose clrData bit is 1. Bits with a 0 in clrData, and every bit in a cycle with clrWe=0, are left unchanged.
- R7: When a bit's event and its clear fall in the same cycle, the bit ends up set.
- R8: irq is high in the cycle after one in which (status & irqEnable) is nonzero, and low in the cycle after one in which it is zero.
- R9: A status bit becomes visible in the cycle after the clock edge at which its event is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleStb | input | 1 | Marks a cycle that carries a new power sample |
| signNeg | input | 1 | Sign of the reactive power sample, 1 = negative |
| noLoad | input | 1 | Reactive power is below the no-load level |
| signPolarity | input | 1 | 0: flag positive-to-negative swings, 1: flag negative-to-positive swings |
| irqEnable | input | 2 | Per-flag interrupt enable (bit 0 sign, bit 1 no-load) |
| clrWe | input | 1 | Write strobe for clearing status |
| clrData | input | 2 | Write-one-to-clear mask for status |
| status | output | 2 | Sticky flags: bit 0 sign change, bit 1 no-load |
| irq | output | 1 | Registered interrupt request |

## Verification
The properties assume that every input is a known synchronous level once reset is released. They also assume that clrData carries meaning only in cycles with clrWe. The bench drives all inputs at the falling edge from a seeded random source. The strobe is kept sparse enough that many cycles pass with a changing sign and no strobe, and clears are mixed with events that fall in the same cycle. Directed sequences cover the reset sign, both polarities, and a clear that collides with an event.

// File: rtl/pwr_evt_pkg.sv
package pwr_evt_pkg;
  localparam int NumFlags  = 2;
  localparam int SignIdx   = 0;
  localparam int NoLoadIdx = 1;

  typedef logic [NumFlags-1:0] flagVec_t;

  // strobes from control to datapath
  typedef struct packed {
    flagVec_t setMask;
    flagVec_t clrMask;
  } evtStrobes_t;
endpackage

// File: rtl/pwr_evt_ctrl.sv
module pwr_evt_ctrl
  import pwr_evt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleStb,
  input  logic        signNeg,
  input  logic        noLoad,
  input  logic        signPolarity,
  input  logic        clrWe,
  input  flagVec_t    clrData,
  output evtStrobes_t strb
);
  logic prevNeg;
  logic swingEvt;

  // the sign seen at the last strobe; reset counts as positive
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevNeg <= 1'b0;
    else if (sampleStb) prevNeg <= signNeg;
  end

  always_comb begin
    if (signPolarity) swingEvt = prevNeg && !signNeg;
    else              swingEvt = !prevNeg && signNeg;
  end

  always_comb begin
    strb = '0;
    strb.setMask[SignIdx]   = sampleStb && swingEvt;
    strb.setMask[NoLoadIdx] = sampleStb && noLoad;
    strb.clrMask            = clrWe ? clrData : '0;
  end
endmodule

// File: rtl/pwr_evt_dp.sv
module pwr_evt_dp
  import pwr_evt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  evtStrobes_t strb,
  input  flagVec_t    irqEnable,
  output flagVec_t    status,
  output logic        irq
);
  flagVec_t statusQ;

  for (genvar i = 0; i < NumFlags; i++) begin : g_flag
    // a set in the same cycle as a clear wins
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                statusQ[i] <= 1'b0;
      else if (strb.setMask[i]) statusQ[i] <= 1'b1;
      else if (strb.clrMask[i]) statusQ[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= |(statusQ & irqEnable);
  end

  assign status = statusQ;
endmodule

// File: rtl/pwr_evt_irq.sv
module pwr_evt_irq
  import pwr_evt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleStb,
  input  logic       signNeg,
  input  logic       noLoad,
  input  logic       signPolarity,
  input  logic [1:0] irqEnable,
  input  logic       clrWe,
  input  logic [1:0] clrData,
  output logic [1:0] status,
  output logic       irq
);
  evtStrobes_t strb;

  pwr_evt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .signNeg(signNeg),
    .noLoad(noLoad), .signPolarity(signPolarity), .clrWe(clrWe),
    .clrData(clrData), .strb(strb)
  );

  pwr_evt_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .irqEnable(irqEnable),
    .status(status), .irq(irq)
  );
endmodule

// File: rtl/pwr_evt_irq_chk.sv
module pwr_evt_irq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sampleStb,
  input logic       noLoad,
  input logic [1:0] irqEnable,
  input logic       clrWe,
  input logic [1:0] clrData,
  input logic [1:0] status,
  input logic       irq
);
  // R6: a flag holds unless it is cleared
  p_sticky_sign_r6: assert property (@(posedge clk) disable iff (!rstN)
    status[0] && !(clrWe && clrData[0]) |=> status[0]);
  p_sticky_noload_r6: assert property (@(posedge clk) disable iff (!rstN)
    status[1] && !(clrWe && clrData[1]) |=> status[1]);

  // R4: the sign flag can only rise after a strobe
  p_sign_on_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[0]) |-> $past(sampleStb));

  // R5 and R7: a no-load sample sets the flag, even with a clear
  p_noload_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb && noLoad |=> status[1]);

  // R6: a clear with no competing event empties the bit
  p_noload_clr_r6: assert property (@(posedge clk) disable iff (!rstN)
    clrWe && clrData[1] && !(sampleStb && noLoad) |=> !status[1]);

  // R8: registered request
  p_irq_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|(status & irqEnable)) |=> irq);
  p_irq_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(|(status & irqEnable)) |=> !irq);
endmodule

bind pwr_evt_irq pwr_evt_irq_chk u_chk (
  .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .noLoad(noLoad),
  .irqEnable(irqEnable), .clrWe(clrWe), .clrData(clrData),
  .status(status), .irq(irq)
);

// File: tb/pwr_evt_irq_tb.sv
module pwr_evt_irq_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleStb = 1'b0, signNeg = 1'b0, noLoad = 1'b0, signPolarity = 1'b0;
  logic [1:0] irqEnable = 2'b00;
  logic       clrWe = 1'b0;
  logic [1:0] clrData = 2'b00;
  logic [1:0] status;
  logic       irq;

  int total = 0;
  int bad = 0;
  logic [1:0] mStat = 2'b00;
  logic       mPrev = 1'b0;
  logic       mIrq = 1'b0;
  int unsigned seed = 32'd7113;

  always #10 clk = ~clk;

  pwr_evt_irq u_dut (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .signNeg(signNeg),
    .noLoad(noLoad), .signPolarity(signPolarity), .irqEnable(irqEnable),
    .clrWe(clrWe), .clrData(clrData), .status(status), .irq(irq)
  );

  function automatic logic [1:0] evtOf(input logic stb, sn, nl, pol, prev);
    logic [1:0] e;
    e = 2'b00;
    if (stb) begin
      e[0] = pol ? (prev && !sn) : (!prev && sn);
      e[1] = nl;
    end
    return e;
  endfunction

  task automatic check(input logic [1:0] act, input logic [1:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // called at a falling edge; drives, steps one clock, compares
  task automatic cycle(input logic stb, sn, nl, pol, input logic [1:0] en,
                       input logic we, input logic [1:0] cd, input string tag);
    logic [1:0] ev;
    sampleStb = stb; signNeg = sn; noLoad = nl; signPolarity = pol;
    irqEnable = en; clrWe = we; clrData = cd;
    ev = evtOf(stb, sn, nl, pol, mPrev);
    if (stb) mPrev = sn;
    mIrq = |(mStat & en);
    mStat = (mStat & ~(we ? cd : 2'b00)) | ev;
    @(posedge clk);
    @(negedge clk);
    check(status, mStat, tag);
    check({1'b0, irq}, {1'b0, mIrq}, "R8 irq");
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(status, 2'b00, "R1 status in reset");
    check({1'b0, irq}, 2'b00, "R1 irq in reset");
    rstN = 1'b1;
    @(negedge clk);
    check(status, 2'b00, "R1 status after reset");

    // R1/R2: first negative strobe after reset counts as a swing
    cycle(1, 1, 0, 0, 2'b00, 0, 2'b00, "R2 swing from reset sign");
    check(status, 2'b01, "R9 sign flag visible");
    cycle(0, 0, 0, 0, 2'b01, 0, 2'b00, "R6 held");
    cycle(0, 0, 0, 0, 2'b01, 0, 2'b00, "R8 irq from enabled flag");
    check({1'b0, irq}, 2'b01, "R8 irq high");
    cycle(0, 0, 0, 0, 2'b01, 1, 2'b10, "R6 zero mask bit kept");
    cycle(0, 0, 0, 0, 2'b01, 0, 2'b01, "R6 clear ignored without we");
    check(status, 2'b01, "R6 still set");
    cycle(0, 0, 0, 0, 2'b01, 1, 2'b01, "R6 cleared");
    check(status, 2'b00, "R6 cleared value");
    // R4: sign toggles without strobes do nothing; remembered sign stays negative
    cycle(0, 0, 0, 0, 2'b11, 0, 2'b00, "R4 no strobe");
    cycle(0, 1, 0, 0, 2'b11, 0, 2'b00, "R4 no strobe");
    cycle(1, 1, 0, 0, 2'b11, 0, 2'b00, "R4 prev was negative, no swing");
    check(status, 2'b00, "R4 no flag");
    // R3: reversed polarity
    cycle(1, 0, 0, 1, 2'b11, 0, 2'b00, "R3 negative to positive");
    check(status, 2'b01, "R3 flag set");
    // R7: event and clear together
    cycle(1, 1, 1, 0, 2'b11, 1, 2'b11, "R7 event beats clear");
    check(status, 2'b11, "R7 both set");
    cycle(0, 0, 1, 0, 2'b11, 1, 2'b11, "R5 noLoad without strobe ignored");
    check(status, 2'b00, "R5 cleared and not reset");

    for (int i = 0; i < 3000; i++) begin
      logic stb, sn, nl, pol, we;
      logic [1:0] en, cd;
      stb = ($urandom(seed) % 4) == 0;
      seed = seed + 1;
      sn  = 1'($urandom(seed)); seed = seed + 3;
      nl  = ($urandom(seed) % 5) == 0; seed = seed + 5;
      pol = ($urandom(seed) % 16) == 0 ? ~signPolarity : signPolarity; seed = seed + 7;
      en  = 2'($urandom(seed)); seed = seed + 11;
      we  = ($urandom(seed) % 3) == 0; seed = seed + 13;
      cd  = 2'($urandom(seed)); seed = seed + 17;
      cycle(stb, sn, nl, pol, en, we, cd, "R6 random status");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule